// File: doc/BRIEF.md
# Adaptive Refresh Interval Controller

This controller decides how long a gain-cell embedded DRAM bank may go between refresh passes. It does not rely on a single worst-case timer. A replica storage cell sits beside the array and decays under the same temperature and access conditions as the array cells. An external sense comparator turns that decay into a level flag, and the controller reads the flag to tune the interval while the chip runs. When the replica leaks quickly (hot, or heavily accessed), the interval shrinks at once. When the replica holds its charge for several intervals in a row, the interval grows one step at a time, which cuts refresh energy.

The interval is `BASE_CYCLES * 2^code`. The 4-bit code is held between `CODE_MIN` and `CODE_MAX`. Each interval follows the same sequence:
- a one-cycle re-arm strobe charges the replica;
- the interval counts down;
- a one-cycle refresh request goes out;
- the controller waits for the row sequencer to acknowledge the finished refresh before it re-arms again.

To keep monitoring cheap, the decay flag is looked at only once every `SAMPLE_EVERY` counting cycles. Access activity is counted during each interval. A busy interval gives no evidence of long retention, so it cannot count towards a step-up.

Top module: `refresh_interval_tuner`

## Requirements
- R1: While reset is asserted, `period_code_o` equals `CODE_MIN` and `refresh_req_o` is 0. In the first cycle after release, `rearm_o` is 1.
- R2: If no decay is detected, the interval counts exactly `BASE_CYCLES * 2^code` cycles, so `refresh_req_o` rises `BASE_CYCLES * 2^code + 1` cycles after the `rearm_o` cycle.
- R3: The decay flag is sampled only on counting cycles whose count (starting from 0) satisfies count mod `SAMPLE_EVERY` = `SAMPLE_EVERY - 1`. The request follows in the cycle after the sampling cycle.
- R4: A sampled decay ends the interval early. The request is raised and the code drops by one, but never below `CODE_MIN`.
- R5: After `SURVIVE_N` qualifying intervals that end without decay, the code rises by one, but never above `CODE_MAX`, and the survival count restarts from zero.
- R6: A decay event clears the survival count.
- R7: An interval with `BUSY_LIMIT` or more access cycles does not count towards survival, and leaves the count unchanged. An interval with `BUSY_LIMIT - 1` access cycles does count.
- R8: `refresh_req_o` is a one-cycle pulse. The controller then waits for `refresh_done_i`. An acknowledge that arrives while the interval is still counting has no effect on it.
- R9: In the cycle after `refresh_done_i` is seen while waiting, `rearm_o` is high for one cycle, and counting starts on the following cycle.
- R10: When decay is sampled on the last cycle of an interval, it takes priority over the normal end: the code drops instead of counting towards survival.
- R11: The code changes by at most one step. It changes only on the cycle in which `refresh_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| decay_i | input | 1 | Replica comparator flag; high once the replica has lost its charge |
| access_i | input | 1 | High in each cycle in which the bank is accessed |
| refresh_done_i | input | 1 | Acknowledge from the row sequencer that the requested refresh is complete |
| refresh_req_o | output | 1 | One-cycle refresh request |
| period_code_o | output | 4 | Current interval code |
| rearm_o | output | 1 | One-cycle strobe that recharges the replica cell |

## Verification
The assertions rely on a few properties of the inputs:
- `decay_i`, once high, stays high until the next re-arm, so sparse sampling cannot miss an event.
- The row sequencer asserts `refresh_done_i` only after it has seen a request.
- Activity on `access_i` is meaningful only while an interval is counting.

The bench follows the same rules. It raises the decay flag at a chosen offset after the re-arm strobe and holds it there. It drops the flag only when it acknowledges the refresh. It drives the access line only during the counting cycles. The one exception is a deliberate mid-interval acknowledge, used to show that such a pulse is ignored.

// File: rtl/rit_pkg.sv
package rit_pkg;
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_RUN  = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } rit_state_e;
endpackage

// File: rtl/rit_interval_timer.sv
module rit_interval_timer #(
  parameter int BASE_LG   = 4,
  parameter int CODE_W    = 4,
  parameter int CODE_MAX  = 5,
  parameter int SAMPLE_LG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              sample_o,
  output logic              last_o
);
  localparam int CNT_W = BASE_LG + CODE_MAX + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             cnt_en;

  always_comb begin
    limit    = (CNT_W'(1) << (BASE_LG + int'(code_i))) - CNT_W'(1);
    sample_o = run_i && (cnt_q[SAMPLE_LG-1:0] == {SAMPLE_LG{1'b1}});
    last_o   = run_i && (cnt_q == limit);
    cnt_en   = clear_i || run_i;
    cnt_d    = clear_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2
  cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= limit));

  // R3
  last_is_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> sample_o);
endmodule

// File: rtl/rit_activity_meter.sv
module rit_activity_meter #(
  parameter int BUSY_LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic access_i,
  output logic busy_o
);
  localparam int AW = $clog2(BUSY_LIMIT + 1);

  logic [AW-1:0] acc_q, acc_d;
  logic          acc_en, hit;

  always_comb begin
    hit    = run_i && access_i && (acc_q != AW'(BUSY_LIMIT));
    acc_en = clear_i || hit;
    acc_d  = clear_i ? '0 : acc_q + AW'(1);
    busy_o = (acc_q == AW'(BUSY_LIMIT)) ||
             (run_i && access_i && (acc_q == AW'(BUSY_LIMIT - 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // R7
  busy_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == AW'(BUSY_LIMIT)) && !clear_i |=> busy_o);
endmodule

// File: rtl/rit_code_tracker.sv
module rit_code_tracker #(
  parameter int CODE_W    = 4,
  parameter int CODE_MIN  = 1,
  parameter int CODE_MAX  = 5,
  parameter int SURVIVE_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              down_i,
  input  logic              end_i,
  input  logic              busy_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int SW = $clog2(SURVIVE_N + 1);

  logic [CODE_W-1:0] code_q, code_d;
  logic [SW-1:0]     surv_q, surv_d;
  logic              upd_en;

  always_comb begin
    code_d = code_q;
    surv_d = surv_q;
    if (down_i) begin
      surv_d = '0;
      if (code_q > CODE_W'(CODE_MIN)) code_d = code_q - CODE_W'(1);
    end else if (end_i && !busy_i) begin
      if (surv_q == SW'(SURVIVE_N - 1)) begin
        surv_d = '0;
        if (code_q < CODE_W'(CODE_MAX)) code_d = code_q + CODE_W'(1);
      end else begin
        surv_d = surv_q + SW'(1);
      end
    end
    upd_en = down_i || end_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_W'(CODE_MIN);
      surv_q <= '0;
    end else if (upd_en) begin
      code_q <= code_d;
      surv_q <= surv_d;
    end
  end

  assign code_o = code_q;

  // R4
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_i && (code_q > CODE_W'(CODE_MIN)) |=> (code_q == $past(code_q) - CODE_W'(1)));

  // R5
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q >= CODE_W'(CODE_MIN)) && (code_q <= CODE_W'(CODE_MAX)));

  // R6
  survive_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_i |=> (surv_q == '0));
endmodule

// File: rtl/refresh_interval_tuner.sv
module refresh_interval_tuner #(
  parameter int CODE_W       = 4,
  parameter int BASE_CYCLES  = 16,
  parameter int CODE_MIN     = 1,
  parameter int CODE_MAX     = 5,
  parameter int SURVIVE_N    = 4,
  parameter int BUSY_LIMIT   = 8,
  parameter int SAMPLE_EVERY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              decay_i,
  input  logic              access_i,
  input  logic              refresh_done_i,
  output logic              refresh_req_o,
  output logic [CODE_W-1:0] period_code_o,
  output logic              rearm_o
);
  import rit_pkg::*;

  localparam int BASE_LG   = $clog2(BASE_CYCLES);
  localparam int SAMPLE_LG = $clog2(SAMPLE_EVERY);

  rit_state_e state_q, state_d;
  logic       run, clear, sample, last, busy, ev_decay, ev_end;

  always_comb begin
    run      = (state_q == ST_RUN);
    clear    = (state_q == ST_ARM);
    ev_decay = sample && decay_i;
    ev_end   = last && !ev_decay;
    state_d  = state_q;
    unique case (state_q)
      ST_ARM:  state_d = ST_RUN;
      ST_RUN:  if (ev_decay || last) state_d = ST_REQ;
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: if (refresh_done_i) state_d = ST_ARM;
      default: state_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARM;
    else         state_q <= state_d;
  end

  assign rearm_o       = (state_q == ST_ARM);
  assign refresh_req_o = (state_q == ST_REQ);

  rit_interval_timer #(
    .BASE_LG(BASE_LG), .CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .SAMPLE_LG(SAMPLE_LG)
  ) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .run_i(run),
    .code_i(period_code_o), .sample_o(sample), .last_o(last)
  );

  rit_activity_meter #(.BUSY_LIMIT(BUSY_LIMIT)) meter_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .run_i(run),
    .access_i(access_i), .busy_o(busy)
  );

  rit_code_tracker #(
    .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .SURVIVE_N(SURVIVE_N)
  ) tracker_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .down_i(ev_decay), .end_i(ev_end),
    .busy_i(busy), .code_o(period_code_o)
  );

  // R8
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_req_o |=> !refresh_req_o);

  // R9
  rearm_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) && refresh_done_i |=> rearm_o);

  // R8
  ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && refresh_done_i && !last && !ev_decay |=> (state_q == ST_RUN));

  // R11
  code_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_code_o != $past(period_code_o)) |->
      (refresh_req_o && ((period_code_o == $past(period_code_o) + CODE_W'(1)) ||
                         (period_code_o == $past(period_code_o) - CODE_W'(1)))));
endmodule

// File: tb/refresh_interval_tuner_tb.sv
module refresh_interval_tuner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 16;
  localparam int CMIN = 1;
  localparam int CMAX = 5;
  localparam int SURV = 4;
  localparam int BUSY = 8;
  localparam int SAMP = 4;

  logic       clk, rst_n, decay, access, done;
  logic       req, rearm;
  logic [3:0] code;

  int n_checks = 0;
  int n_fails  = 0;
  int m_code   = CMIN;
  int m_surv   = 0;

  refresh_interval_tuner #(
    .CODE_W(4), .BASE_CYCLES(BASE), .CODE_MIN(CMIN), .CODE_MAX(CMAX),
    .SURVIVE_N(SURV), .BUSY_LIMIT(BUSY), .SAMPLE_EVERY(SAMP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .decay_i(decay), .access_i(access),
    .refresh_done_i(done), .refresh_req_o(req), .period_code_o(code), .rearm_o(rearm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_interval(input int d, input int acc, input int mid, output int len);
    int j = 0;
    while (!rearm) @(negedge clk);
    forever begin
      if (j > 0 && req) break;
      decay  = (d >= 1) && (j >= d);
      access = (j >= 1) && (j <= acc);
      done   = (mid > 0) && (j == mid);
      @(negedge clk);
      j++;
      if (j > 5000) break;
    end
    len    = j;
    access = 1'b0;
    done   = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R8 request pulse width", int'(req), 0);
    done  = 1'b1;
    decay = 1'b0;
    @(negedge clk);
    done  = 1'b0;
    chk(rearm == 1'b1, "R9 rearm after acknowledge", int'(rearm), 1);
  endtask

  task automatic step(input int d, input int acc, input int mid, input string tag);
    int  lim = BASE << m_code;
    int  c   = d - 1;
    int  len, exp_len;
    bit  dec;
    while ((c % SAMP) != SAMP - 1) c++;
    dec     = (d >= 1) && (c <= lim - 1);
    exp_len = dec ? c + 2 : lim + 1;
    run_interval(d, acc, mid, len);
    chk(len == exp_len, {tag, " interval length"}, len, exp_len);
    if (dec) begin
      m_surv = 0;
      if (m_code > CMIN) m_code--;
    end else if (acc < BUSY) begin
      m_surv++;
      if (m_surv == SURV) begin
        m_surv = 0;
        if (m_code < CMAX) m_code++;
      end
    end
    chk(int'(code) == m_code, {tag, " code"}, int'(code), m_code);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; decay = 1'b0; access = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(code) == CMIN, "R1 reset code", int'(code), CMIN);
    chk(req == 1'b0, "R1 reset request", int'(req), 0);
    rst_n = 1'b1;
    chk(rearm == 1'b1, "R1 rearm after release", int'(rearm), 1);
  endtask

  task automatic test_climb();
    for (int i = 0; i < 16; i++) step(-1, 0, 0, "R2 R5 climb");
    chk(int'(code) == CMAX, "R5 reached top", int'(code), CMAX);
    for (int i = 0; i < 4; i++) step(-1, 0, 0, "R5 clamp at max");
  endtask

  task automatic test_drop();
    step(10, 0, 0, "R3 R4 drop");
    step(5, 0, 0, "R3 R4 drop");
    step(2, 0, 0, "R3 R4 drop");
    step(1, 0, 0, "R3 R4 drop");
    chk(int'(code) == CMIN, "R4 reached bottom", int'(code), CMIN);
    step(3, 0, 0, "R4 clamp at min");
  endtask

  task automatic test_survive_reset();
    for (int i = 0; i < 3; i++) step(-1, 0, 0, "R6 pre");
    step(6, 0, 0, "R6 decay");
    for (int i = 0; i < 3; i++) step(-1, 0, 0, "R6 restart");
    chk(int'(code) == CMIN, "R6 no early rise", int'(code), CMIN);
    step(-1, 0, 0, "R6 rise");
  endtask

  task automatic test_busy();
    for (int i = 0; i < 3; i++) step(-1, 0, 0, "R7 pre");
    step(-1, BUSY, 0, "R7 busy blocks");
    chk(int'(code) == CMIN + 1, "R7 held", int'(code), CMIN + 1);
    step(-1, 0, 0, "R7 resume");
    for (int i = 0; i < 4; i++) step(-1, BUSY - 1, 0, "R7 below limit");
  endtask

  task automatic test_ack_and_priority();
    step(-1, 0, 20, "R8 mid acknowledge ignored");
    step(BASE << m_code, 0, 0, "R10 decay on last cycle");
  endtask

  initial begin
    test_reset();
    test_climb();
    test_drop();
    test_survive_reset();
    test_busy();
    test_ack_and_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule